// File: doc/BRIEF.md
# Block Protection Tuple Checker

This block verifies the 8-byte protection tuple carried with every logical block of a transfer. A command is presented with a one-cycle `cmd_start` pulse, which carries the expected reference tag, the expected application tag and its mask, the protection type, the tuple placement mode, the low 32 bits of the starting block address, the block count and three check enables. The block first screens the command. It then consumes one byte per cycle while `in_valid` is high. For each block the byte stream holds the data bytes first and the metadata bytes after them.

For every block the checker recomputes a 16-bit CRC guard over the data bytes and any metadata bytes that come before the tuple. It also assembles the stored tuple, evaluates the escape rule, and then runs the enabled checks in a fixed order. The first failure ends the command with its own status code. If no check fails, the command ends with a success status after the last block. The result is valid for one cycle, together with the `done` pulse.

Top module: `pi_tuple_checker`

## Requirements
- R1: When `cmd_start` is sampled with type 1, the reference check enabled and `cmd_lba_lo` different from `cmd_ref_tag`, `done` is high on the next cycle with status 4 and `status_dnr` high. No block is checked and the bytes that follow are ignored. The same address mismatch under type 2, or with the reference check off, is accepted.
- R2: The guard is a CRC-16 with polynomial 0x8BB7 and initial value 0. It is processed MSB first, without reflection and without a final XOR, over the data bytes and then the metadata prefix. A guard mismatch ends the command with status 1.
- R3: When `cmd_tuple_first` is 1, the tuple occupies metadata bytes 0 to 7, no metadata is covered by the guard, and the metadata after the tuple is ignored. When it is 0, the tuple is the last 8 metadata bytes and every metadata byte before it is the prefix.
- R4: The tuple fields are big-endian. Tuple bytes 0–1 hold the guard, bytes 2–3 the application tag, and bytes 4–7 the reference tag, each field most significant byte first.
- R5: The application check compares only the bits set in the mask. A block fails with status 2 when (stored AND mask) differs from (expected AND mask).
- R6: A reference tag mismatch ends the command with status 3. The expected tag starts at `cmd_ref_tag` and increases by one after each block for types 1 and 2. For type 3 it stays constant.
- R7: For types 1 and 2, a stored application tag of 0xFFFF makes the block pass with no checks.
- R8: For type 3, a block passes with no checks only when the stored application tag is 0xFFFF and the stored reference tag is 0xFFFFFFFF at the same time.
- R9: The checks run in the order guard, application, reference. The first failing check sets the status, the command ends on that block, and later bytes produce no further `done`.
- R10: A check whose enable is 0 is skipped. With all three enables at 0, every block passes.
- R11: After reset, `done` is 0 and `status` is 0. A command that passes ends with a single `done` pulse carrying status 0. This pulse comes on the cycle after the last byte of block `cmd_blk_cnt_m1`+1 is sampled.
- R12: A `cmd_start` pulse that arrives while a command is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_start | input | 1 | One-cycle command strobe |
| cmd_prot_type | input | 2 | Protection type: 1, 2 or 3 |
| cmd_tuple_first | input | 1 | 1: tuple at the start of the metadata; 0: tuple at its end |
| cmd_chk_guard | input | 1 | Enable for the guard check |
| cmd_chk_app | input | 1 | Enable for the application tag check |
| cmd_chk_ref | input | 1 | Enable for the reference tag check |
| cmd_ref_tag | input | 32 | Expected reference tag of the first block |
| cmd_app_tag | input | 16 | Expected application tag |
| cmd_app_mask | input | 16 | Mask applied to the application tag comparison |
| cmd_lba_lo | input | 32 | Low 32 bits of the starting block address |
| cmd_blk_cnt_m1 | input | CNTW | Number of blocks minus one |
| in_valid | input | 1 | Byte strobe |
| in_byte | input | 8 | Stream byte |
| done | output | 1 | One-cycle end-of-command pulse |
| status | output | 3 | 0 ok, 1 guard, 2 application, 3 reference, 4 invalid command |
| status_dnr | output | 1 | Do-not-retry flag, set with status 4 |

## Verification
Two functions can act on the same closing byte of a block: the escape rule and a check failure. The bench corrupts the guard in a block whose stored application tag is 0xFFFF. Under type 1 it expects a pass. Under type 3 it expects a guard error unless the reference tag is also all ones. A block whose guard, application tag and reference tag are all wrong at once is replayed with the enables removed one at a time, and the reported status must move from 1 to 2 to 3 and finally to a pass. The scoreboard fails any surplus `done` pulse, and this is how it proves that bytes streamed after the first error are ignored.

// File: rtl/pi_check_pkg.sv
package pi_check_pkg;

  typedef enum logic [2:0] {
    ST_OK    = 3'd0,
    ST_GUARD = 3'd1,
    ST_APP   = 3'd2,
    ST_REF   = 3'd3,
    ST_BADPI = 3'd4
  } pi_status_e;

  typedef struct packed {
    logic [15:0] guard;
    logic [15:0] app;
    logic [31:0] reft;
  } pi_tuple_t;

  localparam logic [15:0] GUARD_POLY = 16'h8BB7;

  // One byte through the guard CRC, MSB first.
  function automatic logic [15:0] guard_step(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r;
    r = c ^ {b, 8'h00};
    for (int i = 0; i < 8; i++) begin
      r = r[15] ? ((r << 1) ^ GUARD_POLY) : (r << 1);
    end
    return r;
  endfunction

endpackage

// File: rtl/pi_cmd_screen.sv
module pi_cmd_screen (
  input  logic [1:0]  prot_type,
  input  logic        chk_ref,
  input  logic [31:0] ref_tag,
  input  logic [31:0] lba_lo,
  output logic        reject
);
  always_comb begin
    reject = (prot_type == 2'd1) && chk_ref && (lba_lo != ref_tag);
  end
endmodule

// File: rtl/pi_blk_walker.sv
module pi_blk_walker #(
  parameter int DATA_BYTES = 16,
  parameter int META_BYTES = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clear,
  input  logic                   step,
  input  logic                   tuple_first,
  input  logic [7:0]             byte_in,
  output logic                   blk_end,
  output logic [15:0]            crc_out,
  output pi_check_pkg::pi_tuple_t tuple_view
);
  import pi_check_pkg::*;

  localparam int TOTAL = DATA_BYTES + META_BYTES;
  localparam int POSW  = $clog2(TOTAL);
  localparam logic [POSW:0] LAST_POS   = (POSW+1)'(TOTAL - 1);
  localparam logic [POSW:0] BASE_FIRST = (POSW+1)'(DATA_BYTES);
  localparam logic [POSW:0] BASE_LAST  = (POSW+1)'(DATA_BYTES + META_BYTES - 8);

  logic [POSW:0] pos_q, pos_d;
  logic [15:0]   crc_q, crc_d;
  logic [63:0]   tup_q, tup_d;
  logic [POSW:0] base, rel;
  logic          in_guard, in_tuple;

  always_comb begin
    base     = tuple_first ? BASE_FIRST : BASE_LAST;
    rel      = pos_q - base;
    in_guard = pos_q < base;
    in_tuple = (pos_q >= base) && (rel < (POSW+1)'(8));
    blk_end  = step && (pos_q == LAST_POS);
    crc_out  = crc_q;
    tuple_view = in_tuple ? {tup_q[55:0], byte_in} : tup_q;
  end

  always_comb begin
    pos_d = pos_q;
    crc_d = crc_q;
    tup_d = tup_q;
    if (clear) begin
      pos_d = '0;
      crc_d = '0;
      tup_d = '0;
    end else if (step) begin
      if (blk_end) begin
        pos_d = '0;
        crc_d = '0;
      end else begin
        pos_d = pos_q + 1'b1;
        if (in_guard) crc_d = guard_step(crc_q, byte_in);
      end
      if (in_tuple) tup_d = {tup_q[55:0], byte_in};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
      crc_q <= '0;
      tup_q <= '0;
    end else if (clear || step) begin
      pos_q <= pos_d;
      crc_q <= crc_d;
      tup_q <= tup_d;
    end
  end
endmodule

// File: rtl/pi_tuple_judge.sv
module pi_tuple_judge (
  input  logic [1:0]              prot_type,
  input  logic                    en_guard,
  input  logic                    en_app,
  input  logic                    en_ref,
  input  logic [15:0]             calc_guard,
  input  logic [15:0]             exp_app,
  input  logic [15:0]             app_mask,
  input  logic [31:0]             exp_ref,
  input  pi_check_pkg::pi_tuple_t seen,
  output pi_check_pkg::pi_status_e verdict
);
  import pi_check_pkg::*;

  logic escape;

  always_comb begin
    if (prot_type == 2'd3) escape = (seen.app == 16'hFFFF) && (seen.reft == 32'hFFFF_FFFF);
    else                   escape = (seen.app == 16'hFFFF);

    verdict = ST_OK;
    if (!escape) begin
      if (en_guard && (seen.guard != calc_guard))
        verdict = ST_GUARD;
      else if (en_app && ((seen.app & app_mask) != (exp_app & app_mask)))
        verdict = ST_APP;
      else if (en_ref && (seen.reft != exp_ref))
        verdict = ST_REF;
    end
  end
endmodule

// File: rtl/pi_tuple_checker.sv
module pi_tuple_checker #(
  parameter int DATA_BYTES = 16,
  parameter int META_BYTES = 16,
  parameter int CNTW       = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_start,
  input  logic [1:0]      cmd_prot_type,
  input  logic            cmd_tuple_first,
  input  logic            cmd_chk_guard,
  input  logic            cmd_chk_app,
  input  logic            cmd_chk_ref,
  input  logic [31:0]     cmd_ref_tag,
  input  logic [15:0]     cmd_app_tag,
  input  logic [15:0]     cmd_app_mask,
  input  logic [31:0]     cmd_lba_lo,
  input  logic [CNTW-1:0] cmd_blk_cnt_m1,
  input  logic            in_valid,
  input  logic [7:0]      in_byte,
  output logic            done,
  output logic [2:0]      status,
  output logic            status_dnr
);
  import pi_check_pkg::*;

  // reset: asserted asynchronously, released on the clock
  logic rst_s1_q, rst_s2_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end
  logic rst_int_n;
  assign rst_int_n = rst_s2_q;

  logic            busy_q, busy_d;
  logic [1:0]      typ_q, typ_d;
  logic            first_q, first_d;
  logic            en_g_q, en_g_d, en_a_q, en_a_d, en_r_q, en_r_d;
  logic [31:0]     exp_ref_q, exp_ref_d;
  logic [15:0]     app_q, app_d, mask_q, mask_d;
  logic [CNTW-1:0] left_q, left_d;
  logic            done_q, done_d;
  pi_status_e      stat_q, stat_d;
  logic            dnr_q, dnr_d;

  logic       reject, accept, step, blk_end;
  logic [15:0] crc_now;
  pi_tuple_t  seen;
  pi_status_e verdict;

  assign accept = !busy_q && cmd_start;
  assign step   = busy_q && in_valid;

  pi_cmd_screen u_screen (
    .prot_type (cmd_prot_type),
    .chk_ref   (cmd_chk_ref),
    .ref_tag   (cmd_ref_tag),
    .lba_lo    (cmd_lba_lo),
    .reject    (reject)
  );

  pi_blk_walker #(.DATA_BYTES(DATA_BYTES), .META_BYTES(META_BYTES)) u_walker (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .clear       (accept),
    .step        (step),
    .tuple_first (first_q),
    .byte_in     (in_byte),
    .blk_end     (blk_end),
    .crc_out     (crc_now),
    .tuple_view  (seen)
  );

  pi_tuple_judge u_judge (
    .prot_type  (typ_q),
    .en_guard   (en_g_q),
    .en_app     (en_a_q),
    .en_ref     (en_r_q),
    .calc_guard (crc_now),
    .exp_app    (app_q),
    .app_mask   (mask_q),
    .exp_ref    (exp_ref_q),
    .seen       (seen),
    .verdict    (verdict)
  );

  always_comb begin
    busy_d    = busy_q;
    typ_d     = typ_q;
    first_d   = first_q;
    en_g_d    = en_g_q;
    en_a_d    = en_a_q;
    en_r_d    = en_r_q;
    exp_ref_d = exp_ref_q;
    app_d     = app_q;
    mask_d    = mask_q;
    left_d    = left_q;
    done_d    = 1'b0;
    stat_d    = ST_OK;
    dnr_d     = 1'b0;
    if (!busy_q) begin
      if (cmd_start) begin
        if (reject) begin
          done_d = 1'b1;
          stat_d = ST_BADPI;
          dnr_d  = 1'b1;
        end else begin
          busy_d    = 1'b1;
          typ_d     = cmd_prot_type;
          first_d   = cmd_tuple_first;
          en_g_d    = cmd_chk_guard;
          en_a_d    = cmd_chk_app;
          en_r_d    = cmd_chk_ref;
          exp_ref_d = cmd_ref_tag;
          app_d     = cmd_app_tag;
          mask_d    = cmd_app_mask;
          left_d    = cmd_blk_cnt_m1;
        end
      end
    end else if (blk_end) begin
      if (verdict != ST_OK) begin
        done_d = 1'b1;
        stat_d = verdict;
        busy_d = 1'b0;
      end else if (left_q == '0) begin
        done_d = 1'b1;
        busy_d = 1'b0;
      end else begin
        left_d = left_q - 1'b1;
        if (typ_q != 2'd3) exp_ref_d = exp_ref_q + 32'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      stat_q <= ST_OK;
      dnr_q  <= 1'b0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      stat_q <= stat_d;
      dnr_q  <= dnr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      typ_q     <= '0;
      first_q   <= 1'b0;
      en_g_q    <= 1'b0;
      en_a_q    <= 1'b0;
      en_r_q    <= 1'b0;
      exp_ref_q <= '0;
      app_q     <= '0;
      mask_q    <= '0;
      left_q    <= '0;
    end else if (accept || blk_end) begin
      typ_q     <= typ_d;
      first_q   <= first_d;
      en_g_q    <= en_g_d;
      en_a_q    <= en_a_d;
      en_r_q    <= en_r_d;
      exp_ref_q <= exp_ref_d;
      app_q     <= app_d;
      mask_q    <= mask_d;
      left_q    <= left_d;
    end
  end

  assign done       = done_q;
  assign status     = stat_q;
  assign status_dnr = dnr_q;
endmodule

// File: rtl/pi_tuple_checker_sva.sv
module pi_tuple_checker_sva (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_start,
  input logic        done,
  input logic [2:0]  status,
  input logic        status_dnr,
  input logic        busy,
  input logic        en_g,
  input logic        en_a,
  input logic        en_r,
  input logic [1:0]  typ,
  input logic [31:0] exp_ref
);
  // R1: the do-not-retry flag travels only with the invalid-command code
  assert_dnr_code_R1: assert property (@(posedge clk) disable iff (!rst_n)
    status_dnr |-> (done && status == 3'd4));

  // R1: an invalid-command result follows a command strobe taken while idle
  assert_reject_origin_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (done && status == 3'd4) |-> ($past(cmd_start) && !$past(busy)));

  // R10: a check error is reported only when that check was enabled
  assert_guard_enabled_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && status == 3'd1) |-> en_g);
  assert_app_enabled_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && status == 3'd2) |-> en_a);
  assert_ref_enabled_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && status == 3'd3) |-> en_r);

  // R6: the expected reference tag does not move under type 3
  assert_type3_ref_fixed_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && typ == 2'd3) |-> $stable(exp_ref));

  // R11: every done pulse comes from a running command or a fresh strobe
  assert_done_source_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(busy) || $past(cmd_start)));

  // R11: status is zero outside the done pulse
  assert_status_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> (status == 3'd0));
endmodule

bind pi_tuple_checker pi_tuple_checker_sva u_sva (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_start  (cmd_start),
  .done       (done),
  .status     (status),
  .status_dnr (status_dnr),
  .busy       (busy_q),
  .en_g       (en_g_q),
  .en_a       (en_a_q),
  .en_r       (en_r_q),
  .typ        (typ_q),
  .exp_ref    (exp_ref_q)
);

// File: tb/pi_tuple_checker_test.sv
`timescale 1ns/1ps
module pi_tuple_checker_test;
  localparam int DB = 16;
  localparam int MB = 16;
  localparam int TB = DB + MB;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_start = 1'b0;
  logic [1:0]  cmd_prot_type = '0;
  logic        cmd_tuple_first = 1'b0;
  logic        cmd_chk_guard = 1'b0, cmd_chk_app = 1'b0, cmd_chk_ref = 1'b0;
  logic [31:0] cmd_ref_tag = '0, cmd_lba_lo = '0;
  logic [15:0] cmd_app_tag = '0, cmd_app_mask = '0;
  logic [7:0]  cmd_blk_cnt_m1 = '0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_byte = '0;
  logic        done, status_dnr;
  logic [2:0]  status;

  always #2 clk = ~clk;

  pi_tuple_checker uut (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_prot_type(cmd_prot_type),
    .cmd_tuple_first(cmd_tuple_first), .cmd_chk_guard(cmd_chk_guard),
    .cmd_chk_app(cmd_chk_app), .cmd_chk_ref(cmd_chk_ref), .cmd_ref_tag(cmd_ref_tag),
    .cmd_app_tag(cmd_app_tag), .cmd_app_mask(cmd_app_mask), .cmd_lba_lo(cmd_lba_lo),
    .cmd_blk_cnt_m1(cmd_blk_cnt_m1), .in_valid(in_valid), .in_byte(in_byte),
    .done(done), .status(status), .status_dnr(status_dnr)
  );

  typedef struct {
    logic [2:0] st;
    string      tag;
  } exp_item_t;

  exp_item_t sb[$];
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // bitwise reference CRC: feedback formed per input bit
  function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    logic fb;
    r = c;
    for (int i = 7; i >= 0; i--) begin
      fb = r[15] ^ d[i];
      r  = {r[14:0], 1'b0} ^ (fb ? 16'h8BB7 : 16'h0000);
    end
    return r;
  endfunction

  // monitor: every done pulse must match the oldest expectation
  always @(negedge clk) begin
    if (rst_n && done) begin
      checks++;
      if (sb.size() == 0) begin
        errors++;
        $display("FAIL R9 surplus done: actual status %0d expected no done", status);
      end else begin
        exp_item_t e;
        e = sb.pop_front();
        if (status !== e.st || status_dnr !== (e.st == 3'd4)) begin
          errors++;
          $display("FAIL %s status actual %0d dnr %0b expected %0d dnr %0b",
                   e.tag, status, status_dnr, e.st, (e.st == 3'd4));
        end
      end
    end
  end

  // kind: 0 clean, 1 guard, 2 app, 3 ref, 4 app all ones + guard,
  //       5 app and ref all ones + guard, 7 all three wrong
  task automatic run_cmd(input int typ, input bit first, input bit g, input bit a,
                         input bit r, input logic [31:0] rt, input logic [15:0] at,
                         input logic [15:0] am, input logic [31:0] lba, input int nb,
                         input int bad_blk, input int kind, input bit poke,
                         input string tag);
    exp_item_t e;
    logic [2:0] exp_st;
    logic [7:0] blk [TB];
    int base;
    exp_st = 3'd0;
    base = first ? DB : DB + MB - 8;
    e.tag = tag;
    if (typ == 1 && r && lba != rt) exp_st = 3'd4;

    // compute expectation first
    if (exp_st != 3'd4) begin
      for (int b = 0; b < nb; b++) begin
        logic [15:0] crc, sg, sa;
        logic [31:0] sr, eref;
        logic esc;
        logic [2:0] v;
        crc = 16'h0;
        for (int i = 0; i < base; i++)
          crc = ref_crc(crc, 8'((b * 37 + i * 11 + 5) & 255));
        eref = rt + ((typ != 3) ? 32'(b) : 32'd0);
        sg = crc; sa = (at & am) | (~am & 16'hA5C3); sr = eref;
        if (b == bad_blk) begin
          case (kind)
            1: sg = sg ^ 16'h0001;
            2: sa = sa ^ 16'h0100;
            3: sr = sr ^ 32'h1;
            4: begin sa = 16'hFFFF; sg = sg ^ 16'h0001; end
            5: begin sa = 16'hFFFF; sr = 32'hFFFF_FFFF; sg = sg ^ 16'h0001; end
            7: begin sg = sg ^ 16'h0001; sa = sa ^ 16'h0100; sr = sr ^ 32'h1; end
            default: ;
          endcase
        end
        esc = (typ == 3) ? (sa == 16'hFFFF && sr == 32'hFFFF_FFFF) : (sa == 16'hFFFF);
        v = 3'd0;
        if (!esc) begin
          if (g && sg != crc) v = 3'd1;
          else if (a && ((sa & am) != (at & am))) v = 3'd2;
          else if (r && sr != eref) v = 3'd3;
        end
        if (exp_st == 3'd0) exp_st = v;
      end
    end
    e.st = exp_st;
    sb.push_back(e);

    @(negedge clk);
    cmd_prot_type = 2'(typ); cmd_tuple_first = first;
    cmd_chk_guard = g; cmd_chk_app = a; cmd_chk_ref = r;
    cmd_ref_tag = rt; cmd_app_tag = at; cmd_app_mask = am; cmd_lba_lo = lba;
    cmd_blk_cnt_m1 = 8'(nb - 1);
    cmd_start = 1'b1;
    @(negedge clk);
    cmd_start = 1'b0;

    // stream every block, including after an expected error
    for (int b = 0; b < nb; b++) begin
      logic [15:0] crc, sg, sa;
      logic [31:0] sr;
      crc = 16'h0;
      for (int i = 0; i < TB; i++) blk[i] = 8'((b * 37 + i * 11 + 5) & 255);
      for (int i = 0; i < base; i++) crc = ref_crc(crc, blk[i]);
      sg = crc; sa = (at & am) | (~am & 16'hA5C3);
      sr = rt + ((typ != 3) ? 32'(b) : 32'd0);
      if (b == bad_blk) begin
        case (kind)
          1: sg = sg ^ 16'h0001;
          2: sa = sa ^ 16'h0100;
          3: sr = sr ^ 32'h1;
          4: begin sa = 16'hFFFF; sg = sg ^ 16'h0001; end
          5: begin sa = 16'hFFFF; sr = 32'hFFFF_FFFF; sg = sg ^ 16'h0001; end
          7: begin sg = sg ^ 16'h0001; sa = sa ^ 16'h0100; sr = sr ^ 32'h1; end
          default: ;
        endcase
      end
      {blk[base], blk[base+1]} = sg;
      {blk[base+2], blk[base+3]} = sa;
      {blk[base+4], blk[base+5], blk[base+6], blk[base+7]} = sr;
      for (int i = 0; i < TB; i++) begin
        in_valid = 1'b1;
        in_byte  = blk[i];
        if (poke && b == 0 && i == 3) begin
          cmd_prot_type = 2'd1; cmd_chk_ref = 1'b1;
          cmd_lba_lo = ~rt; cmd_start = 1'b1;
        end else begin
          cmd_start = 1'b0;
        end
        @(negedge clk);
      end
    end
    in_valid = 1'b0;
    cmd_start = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    checks++;
    if (done !== 1'b0 || status !== 3'd0) begin
      errors++;
      $display("FAIL R11 reset: actual done %0b status %0d expected 0 0", done, status);
    end

    // R11 R4 R6: clean type 1 transfer, tuple at metadata end
    run_cmd(1, 0, 1, 1, 1, 32'h1000, 16'h1234, 16'hFFFF, 32'h1000, 3, -1, 0, 0, "R11");
    // R2: guard corrupted in block 1
    run_cmd(1, 0, 1, 1, 1, 32'h20, 16'h0042, 16'hFFFF, 32'h20, 3, 1, 1, 0, "R2");
    // R3: tuple first, clean, then guard error
    run_cmd(2, 1, 1, 1, 1, 32'h77, 16'h0101, 16'hFFFF, 32'h5, 2, -1, 0, 0, "R3");
    run_cmd(2, 1, 1, 1, 1, 32'h77, 16'h0101, 16'hFFFF, 32'h5, 2, 0, 1, 0, "R3");
    // R5: masked bit differs -> error; bits outside mask differ -> pass
    run_cmd(2, 0, 1, 1, 1, 32'h9, 16'h3300, 16'hFF00, 32'h9, 2, 1, 2, 0, "R5");
    run_cmd(2, 0, 1, 1, 1, 32'h9, 16'h3300, 16'h00FF, 32'h9, 2, -1, 0, 0, "R5");
    // R6: reference error in block 2; type 3 keeps constant tag
    run_cmd(2, 0, 1, 1, 1, 32'hFFFF_FFFE, 16'h0007, 16'hFFFF, 32'h0, 3, 2, 3, 0, "R6");
    run_cmd(3, 0, 1, 1, 1, 32'hABCD, 16'h0007, 16'hFFFF, 32'h0, 3, -1, 0, 0, "R6");
    // R7: escape under type 1 hides a bad guard
    run_cmd(1, 0, 1, 1, 1, 32'h40, 16'h0008, 16'hFFFF, 32'h40, 2, 1, 4, 0, "R7");
    // R8: type 3 needs both escape values
    run_cmd(3, 0, 1, 1, 1, 32'h40, 16'h0008, 16'hFFFF, 32'h0, 2, 1, 4, 0, "R8");
    run_cmd(3, 0, 1, 1, 1, 32'h40, 16'h0008, 16'hFFFF, 32'h0, 2, 1, 5, 0, "R8");
    // R9: order of checks, first error wins; rest of stream ignored
    run_cmd(1, 0, 1, 1, 1, 32'h3, 16'h0011, 16'hFFFF, 32'h3, 3, 0, 7, 0, "R9");
    run_cmd(1, 0, 0, 1, 1, 32'h3, 16'h0011, 16'hFFFF, 32'h3, 3, 0, 7, 0, "R9");
    run_cmd(1, 0, 0, 0, 1, 32'h3, 16'h0011, 16'hFFFF, 32'h3, 3, 0, 7, 0, "R9");
    // R10: all checks off
    run_cmd(1, 0, 0, 0, 0, 32'h3, 16'h0011, 16'hFFFF, 32'h3, 2, 0, 7, 0, "R10");
    // R1: command screening
    run_cmd(1, 0, 1, 1, 1, 32'h100, 16'h0011, 16'hFFFF, 32'h101, 2, -1, 0, 0, "R1");
    run_cmd(2, 0, 1, 1, 1, 32'h100, 16'h0011, 16'hFFFF, 32'h101, 2, -1, 0, 0, "R1");
    run_cmd(1, 0, 1, 1, 0, 32'h100, 16'h0011, 16'hFFFF, 32'h101, 2, -1, 0, 0, "R1");
    // R12: strobe during a running command ignored
    run_cmd(1, 0, 1, 1, 1, 32'h55, 16'h0022, 16'hFFFF, 32'h55, 2, -1, 0, 1, "R12");

    repeat (10) @(negedge clk);
    checks++;
    if (sb.size() != 0) begin
      errors++;
      $display("FAIL R11 missing done: actual pending %0d expected 0", sb.size());
    end
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule